// File: doc/BRIEF.md
# Message Object List Manager

This block keeps a pool of message objects organised as singly linked lists hanging off a small set of list heads. List 0 is the free pool, list 1 belongs to bus node 0, list 2 to bus node 1, and the remaining lists are general purpose. Software drives the block through one 32-bit command panel. It writes a command code and two argument bytes in a single word, then polls the status byte until the block reports that the operation is done.

The commands do the following:
- rebuild every list from scratch;
- move a named object to the end of any list;
- take the first free object and append it to a list;
- place an object directly in front of, or directly after, a chosen target object.

Each placement command has a static form, which names the object to move, and a dynamic form, which takes the head of the free pool. Dynamic commands return the index of the object they took. Bad arguments, and dynamic commands on an empty pool, set an error bit and leave every list as it was.

The block finds predecessors by walking a list one link per clock cycle. A command therefore occupies the block for a data-dependent number of cycles. Two read ports show each object's next pointer and list number, and each list's head and empty state, so software can follow the chains.

Top module: `objlist_mgr`

## Requirements
- R1: After reset, and after command 0x01, all objects sit in list 0 in index order with next pointer i+1. The last object's next pointer equals its own index, which is the end-of-list encoding in every list. All other lists are empty.
- R2: The panel write word carries the command in bits 7:0, argument 1 in bits 23:16 and argument 2 in bits 31:24. The panel read word carries the last accepted command in bits 7:0 and the status in bits 15:8 (bit 8 busy, bit 9 result-busy). It carries result argument 1 in bits 23:16, and result argument 2 in bits 31:24, which is argument 2 bits 6:0 with bit 31 as the error flag.
- R3: Busy and result-busy are both high on the cycle after an accepted write. Result-busy never stays high after busy has fallen. Busy falls once the list update is complete. A write made while busy is high changes nothing.
- R4: Command 0x02 removes the object named by argument 1 from its list, keeping the order of the remaining members, and appends it as the tail of the list named by argument 2. Result argument 1 is that object.
- R5: Command 0x03 removes the head of list 0 and appends it to the list named by argument 2. Result argument 1 is its index.
- R6: Commands 0x04 (object from argument 1) and 0x05 (head of list 0) place the object immediately in front of the target object named by argument 2, in the target's list. If the target was the head, the object becomes the new head.
- R7: Commands 0x06 (object from argument 1) and 0x07 (head of list 0) place the object immediately after the target object named by argument 2. If the target was the tail, the object becomes the new tail.
- R8: A dynamic command (0x03, 0x05, 0x07) issued while list 0 is empty sets the error flag, echoes argument 1 as result argument 1 and leaves all lists unchanged.
- R9: Each of the following sets the error flag, echoes argument 1 and leaves all lists unchanged: an object index of 32 or more, a list number of 8 or more for 0x02/0x03, a target of 32 or more, an object equal to its target, or any command code above 0x07.
- R10: Command 0x00 completes without error, changes no list and echoes both arguments.
- R11: The object read port gives the selected object's next pointer (8 bits) and list number (4 bits). The list read port gives the selected list's head index and an empty flag. Both ports are combinational views of the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pan_we | input | 1 | Panel write strobe |
| pan_wdata | input | 32 | Panel write word: command, arguments |
| pan_rdata | output | 32 | Panel read word: command, status, results |
| obj_sel | input | 5 | Object index for the object read port |
| obj_next | output | 8 | Next pointer of the selected object |
| obj_list | output | 4 | List number of the selected object |
| lst_sel | input | 3 | List number for the list read port |
| lst_head | output | 8 | Head object of the selected list |
| lst_empty | output | 1 | Selected list holds no objects |

## Verification
After every command, the bench follows each list through the read ports and compares it with an ordered model built from the requirements.

Static moves are tried in three positions: from the free pool into an empty list, into a list that already has members, and onto the end of the object's own list. The last case shows whether removal and append work together correctly.

Insertion in front of a target is tried both at the head and in the middle of a list, which separates the head-pointer update from the predecessor update. Insertion after a target is tried both in the middle and at the tail, which separates the tail-pointer update.

Two further sequences cover the pool limits and the error paths. The free pool is drained one dynamic allocation at a time, and dynamic commands on the empty pool then show that failure changes nothing. Out-of-range arguments, an object equal to its target, and an undefined command code are checked against the same unchanged-state comparison.

// File: rtl/olm_pkg.sv
package olm_pkg;

    localparam int PTR_W  = 8;
    localparam int LNUM_W = 4;

    localparam logic [7:0] OP_NOP    = 8'h00;
    localparam logic [7:0] OP_INIT   = 8'h01;
    localparam logic [7:0] OP_SALLOC = 8'h02;
    localparam logic [7:0] OP_DALLOC = 8'h03;
    localparam logic [7:0] OP_SBEF   = 8'h04;
    localparam logic [7:0] OP_DBEF   = 8'h05;
    localparam logic [7:0] OP_SBEH   = 8'h06;
    localparam logic [7:0] OP_DBEH   = 8'h07;

    typedef enum logic [1:0] {PL_TAIL, PL_BEFORE, PL_BEHIND} place_e;

    typedef enum logic [2:0] {
        U_NONE, U_INIT, U_UNLINK, U_APPEND, U_BEFORE, U_BEHIND
    } upd_kind_e;

    typedef struct packed {
        upd_kind_e           kind;
        logic [PTR_W-1:0]    obj;
        logic [PTR_W-1:0]    tgt;
        logic [PTR_W-1:0]    pred;
        logic                pred_ok;
        logic [LNUM_W-1:0]   lnum;
    } upd_t;

    typedef struct packed {
        logic                err;
        logic                nop;
        logic                init;
        place_e              place;
        logic [PTR_W-1:0]    obj;
        logic [PTR_W-1:0]    tgt;
        logic [LNUM_W-1:0]   lnum;
    } dec_t;

    function automatic logic takes_free(input logic [7:0] code);
        return (code == OP_DALLOC) || (code == OP_DBEF) || (code == OP_DBEH);
    endfunction

    function automatic place_e place_of(input logic [7:0] code);
        case (code)
            OP_SBEF, OP_DBEF: return PL_BEFORE;
            OP_SBEH, OP_DBEH: return PL_BEHIND;
            default:          return PL_TAIL;
        endcase
    endfunction

    function automatic upd_kind_e link_kind(input place_e p);
        case (p)
            PL_BEFORE: return U_BEFORE;
            PL_BEHIND: return U_BEHIND;
            default:   return U_APPEND;
        endcase
    endfunction

endpackage

// File: rtl/olm_decode.sv
module olm_decode
    import olm_pkg::*;
#(
    parameter int NOBJ  = 32,
    parameter int NLIST = 8
) (
    input  logic [7:0]        code,
    input  logic [7:0]        a1,
    input  logic [7:0]        a2,
    input  logic              free_live,
    input  logic [PTR_W-1:0]  free_head,
    input  logic [LNUM_W-1:0] tgt_list,
    output dec_t              dec
);

    localparam logic [8:0] OBJ_LIM = 9'(NOBJ);
    localparam logic [8:0] LST_LIM = 9'(NLIST);

    logic             a1_ok;
    logic             a2_obj_ok;
    logic             a2_lst_ok;
    logic [PTR_W-1:0] src;

    assign a1_ok     = {1'b0, a1} < OBJ_LIM;
    assign a2_obj_ok = {1'b0, a2} < OBJ_LIM;
    assign a2_lst_ok = {1'b0, a2} < LST_LIM;
    assign src       = takes_free(code) ? free_head : a1;

    always_comb begin
        dec       = '0;
        dec.place = place_of(code);
        dec.obj   = src;
        dec.tgt   = a2;
        dec.lnum  = a2[LNUM_W-1:0];
        case (code)
            OP_NOP:  dec.nop  = 1'b1;
            OP_INIT: dec.init = 1'b1;
            OP_SALLOC: dec.err = !(a1_ok && a2_lst_ok);
            OP_DALLOC: dec.err = !(free_live && a2_lst_ok);
            OP_SBEF, OP_SBEH: begin
                dec.err  = !(a1_ok && a2_obj_ok) || (a1 == a2);
                dec.lnum = tgt_list;
            end
            OP_DBEF, OP_DBEH: begin
                dec.err  = !(free_live && a2_obj_ok) || (free_head == a2);
                dec.lnum = tgt_list;
            end
            default: dec.err = 1'b1;
        endcase
    end

endmodule

// File: rtl/olm_store.sv
module olm_store
    import olm_pkg::*;
#(
    parameter int NOBJ  = 32,
    parameter int NLIST = 8,
    localparam int IW   = $clog2(NOBJ),
    localparam int LW   = $clog2(NLIST)
) (
    input  logic          clk,
    input  logic          rst,
    input  upd_t          upd,
    output logic [IW-1:0] nxt_q  [NOBJ],
    output logic [LW-1:0] lst_q  [NOBJ],
    output logic [IW-1:0] head_q [NLIST],
    output logic [NLIST-1:0] live_q
);

    logic [IW-1:0] tail_q [NLIST];
    logic [IW-1:0] u_o, u_t, u_p;
    logic [LW-1:0] u_l, o_home;
    logic          unused_hi;

    assign u_o    = upd.obj[IW-1:0];
    assign u_t    = upd.tgt[IW-1:0];
    assign u_p    = upd.pred[IW-1:0];
    assign u_l    = upd.lnum[LW-1:0];
    assign o_home = lst_q[u_o];
    assign unused_hi = ^{upd.obj >> IW, upd.tgt >> IW, upd.pred >> IW, upd.lnum >> LW};

    always_ff @(posedge clk) begin
        if (rst || upd.kind == U_INIT) begin
            for (int i = 0; i < NOBJ; i++) begin
                nxt_q[i] <= (i == NOBJ - 1) ? IW'(i) : IW'(i + 1);
                lst_q[i] <= '0;
            end
            for (int l = 0; l < NLIST; l++) begin
                head_q[l] <= '0;
                tail_q[l] <= IW'(NOBJ - 1);
            end
            live_q <= {{(NLIST-1){1'b0}}, 1'b1};
        end else begin
            case (upd.kind)
                U_UNLINK: begin
                    if (!upd.pred_ok) begin
                        if (tail_q[o_home] == u_o) live_q[o_home] <= 1'b0;
                        else                       head_q[o_home] <= nxt_q[u_o];
                    end else if (tail_q[o_home] == u_o) begin
                        tail_q[o_home] <= u_p;
                        nxt_q[u_p]     <= u_p;
                    end else begin
                        nxt_q[u_p] <= nxt_q[u_o];
                    end
                end
                U_APPEND: begin
                    lst_q[u_o] <= u_l;
                    nxt_q[u_o] <= u_o;
                    tail_q[u_l] <= u_o;
                    if (live_q[u_l]) begin
                        nxt_q[tail_q[u_l]] <= u_o;
                    end else begin
                        head_q[u_l] <= u_o;
                        live_q[u_l] <= 1'b1;
                    end
                end
                U_BEFORE: begin
                    lst_q[u_o] <= u_l;
                    nxt_q[u_o] <= u_t;
                    if (upd.pred_ok) nxt_q[u_p]  <= u_o;
                    else             head_q[u_l] <= u_o;
                end
                U_BEHIND: begin
                    lst_q[u_o] <= u_l;
                    nxt_q[u_t] <= u_o;
                    if (tail_q[u_l] == u_t) begin
                        nxt_q[u_o]  <= u_o;
                        tail_q[u_l] <= u_o;
                    end else begin
                        nxt_q[u_o] <= nxt_q[u_t];
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NLIST; g++) begin : g_chk
        AST_TAIL_SELF: assert property (@(posedge clk) disable iff (rst)
            live_q[g] |-> (nxt_q[tail_q[g]] == tail_q[g])); // R1
        AST_HEAD_OWN: assert property (@(posedge clk) disable iff (rst)
            live_q[g] |-> (lst_q[head_q[g]] == LW'(g))); // R11
    end

endmodule

// File: rtl/olm_seq.sv
module olm_seq
    import olm_pkg::*;
#(
    parameter int NOBJ  = 32,
    parameter int NLIST = 8,
    localparam int IW   = $clog2(NOBJ),
    localparam int LW   = $clog2(NLIST)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [31:0]   wdata,
    input  dec_t          dec,
    input  logic [IW-1:0] nxt_q  [NOBJ],
    input  logic [LW-1:0] lst_q  [NOBJ],
    input  logic [IW-1:0] head_q [NLIST],
    output logic          busy,
    output logic          rbusy,
    output logic [7:0]    cmd_q,
    output logic [7:0]    a1_q,
    output logic [7:0]    a2_q,
    output logic [7:0]    res1,
    output logic [7:0]    res2,
    output upd_t          upd
);

    typedef enum logic [2:0] {S_IDLE, S_DEC, S_WALK, S_UNLINK, S_LINK} st_e;

    st_e              st;
    logic [PTR_W-1:0] o_q, t_q;
    logic [LNUM_W-1:0] l_q;
    place_e           place_q;
    logic             phase_q, first_q, predok_q;
    logic [IW-1:0]    goal_q, cur_q, pred_q, cur_eff;
    logic [LW-1:0]    wl_q;
    logic [IW:0]      wcnt;
    logic             unused_wd;

    assign unused_wd = ^wdata[15:8];
    assign cur_eff   = first_q ? head_q[wl_q] : cur_q;

    always_comb begin
        upd         = '0;
        upd.kind    = U_NONE;
        upd.obj     = o_q;
        upd.tgt     = t_q;
        upd.pred    = PTR_W'(pred_q);
        upd.pred_ok = predok_q;
        upd.lnum    = l_q;
        case (st)
            S_DEC:    if (dec.init && !dec.err) upd.kind = U_INIT;
            S_UNLINK: upd.kind = U_UNLINK;
            S_LINK:   upd.kind = link_kind(place_q);
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; busy <= 1'b0; rbusy <= 1'b0;
            cmd_q <= '0; a1_q <= '0; a2_q <= '0; res1 <= '0; res2 <= '0;
            o_q <= '0; t_q <= '0; l_q <= '0; place_q <= PL_TAIL;
            phase_q <= 1'b0; first_q <= 1'b1; predok_q <= 1'b0;
            goal_q <= '0; cur_q <= '0; pred_q <= '0; wl_q <= '0; wcnt <= '0;
        end else begin
            case (st)
                S_IDLE: if (we) begin
                    cmd_q <= wdata[7:0];
                    a1_q  <= wdata[23:16];
                    a2_q  <= wdata[31:24];
                    busy  <= 1'b1;
                    rbusy <= 1'b1;
                    st    <= S_DEC;
                end
                S_DEC: begin
                    res1  <= (dec.err || dec.nop || dec.init) ? a1_q : dec.obj;
                    res2  <= {dec.err, a2_q[6:0]};
                    rbusy <= 1'b0;
                    if (dec.err || dec.nop || dec.init) begin
                        busy <= 1'b0;
                        st   <= S_IDLE;
                    end else begin
                        o_q     <= dec.obj;
                        t_q     <= dec.tgt;
                        l_q     <= dec.lnum;
                        place_q <= dec.place;
                        goal_q  <= dec.obj[IW-1:0];
                        wl_q    <= lst_q[dec.obj[IW-1:0]];
                        phase_q <= 1'b0;
                        first_q <= 1'b1;
                        wcnt    <= '0;
                        st      <= S_WALK;
                    end
                end
                S_WALK: begin
                    if (first_q && head_q[wl_q] == goal_q) begin
                        predok_q <= 1'b0;
                        st       <= phase_q ? S_LINK : S_UNLINK;
                    end else if (nxt_q[cur_eff] == goal_q) begin
                        pred_q   <= cur_eff;
                        predok_q <= 1'b1;
                        st       <= phase_q ? S_LINK : S_UNLINK;
                    end else begin
                        cur_q   <= nxt_q[cur_eff];
                        first_q <= 1'b0;
                        wcnt    <= wcnt + 1'b1;
                    end
                end
                S_UNLINK: begin
                    if (place_q == PL_BEFORE) begin
                        phase_q <= 1'b1;
                        goal_q  <= t_q[IW-1:0];
                        wl_q    <= l_q[LW-1:0];
                        first_q <= 1'b1;
                        wcnt    <= '0;
                        st      <= S_WALK;
                    end else begin
                        st <= S_LINK;
                    end
                end
                S_LINK: begin
                    busy <= 1'b0;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_RBUSY_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rbusy |-> busy); // R3
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && we) |=> ($stable(cmd_q) && $stable(a1_q) && $stable(a2_q))); // R3
    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == S_WALK) |-> (wcnt < (IW+1)'(NOBJ))); // R3
    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st == S_DEC && dec.err) |=> !busy); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rbusy |=> ($stable(res1) && $stable(res2))); // R2

endmodule

// File: rtl/objlist_mgr.sv
module objlist_mgr
    import olm_pkg::*;
#(
    parameter int NOBJ  = 32,
    parameter int NLIST = 8,
    localparam int IW   = $clog2(NOBJ),
    localparam int LW   = $clog2(NLIST)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pan_we,
    input  logic [31:0]   pan_wdata,
    output logic [31:0]   pan_rdata,
    input  logic [IW-1:0] obj_sel,
    output logic [7:0]    obj_next,
    output logic [3:0]    obj_list,
    input  logic [LW-1:0] lst_sel,
    output logic [7:0]    lst_head,
    output logic          lst_empty
);

    logic [IW-1:0]    nxt_q  [NOBJ];
    logic [LW-1:0]    lst_q  [NOBJ];
    logic [IW-1:0]    head_q [NLIST];
    logic [NLIST-1:0] live_q;
    dec_t             dec;
    upd_t             upd;
    logic             busy, rbusy;
    logic [7:0]       cmd_q, a1_q, a2_q, res1, res2;

    olm_decode #(.NOBJ(NOBJ), .NLIST(NLIST)) u_dec (
        .code      (cmd_q),
        .a1        (a1_q),
        .a2        (a2_q),
        .free_live (live_q[0]),
        .free_head (PTR_W'(head_q[0])),
        .tgt_list  (LNUM_W'(lst_q[a2_q[IW-1:0]])),
        .dec       (dec)
    );

    olm_seq #(.NOBJ(NOBJ), .NLIST(NLIST)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .we     (pan_we),
        .wdata  (pan_wdata),
        .dec    (dec),
        .nxt_q  (nxt_q),
        .lst_q  (lst_q),
        .head_q (head_q),
        .busy   (busy),
        .rbusy  (rbusy),
        .cmd_q  (cmd_q),
        .a1_q   (a1_q),
        .a2_q   (a2_q),
        .res1   (res1),
        .res2   (res2),
        .upd    (upd)
    );

    olm_store #(.NOBJ(NOBJ), .NLIST(NLIST)) u_store (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .nxt_q  (nxt_q),
        .lst_q  (lst_q),
        .head_q (head_q),
        .live_q (live_q)
    );

    assign pan_rdata = {res2, res1, 6'b0, rbusy, busy, cmd_q};
    assign obj_next  = PTR_W'(nxt_q[obj_sel]);
    assign obj_list  = LNUM_W'(lst_q[obj_sel]);
    assign lst_head  = PTR_W'(head_q[lst_sel]);
    assign lst_empty = !live_q[lst_sel];

endmodule

// File: tb/tb_objlist_mgr.sv
`timescale 1ns/1ps
module tb_objlist_mgr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pan_we = 1'b0;
    logic [31:0] pan_wdata = '0;
    logic [31:0] pan_rdata;
    logic [4:0]  obj_sel = '0;
    logic [7:0]  obj_next;
    logic [3:0]  obj_list;
    logic [2:0]  lst_sel = '0;
    logic [7:0]  lst_head;
    logic        lst_empty;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct packed { logic [7:0] r1; logic [7:0] r2; } exp_t;
    exp_t sbq[$];

    int ord [8][32];
    int len [8];

    always #2.5 clk = ~clk;

    objlist_mgr dut (
        .clk(clk), .rst(rst), .pan_we(pan_we), .pan_wdata(pan_wdata),
        .pan_rdata(pan_rdata), .obj_sel(obj_sel), .obj_next(obj_next),
        .obj_list(obj_list), .lst_sel(lst_sel), .lst_head(lst_head),
        .lst_empty(lst_empty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: result bytes are compared when busy falls
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            prev_busy <= 1'b0;
        end else begin
            if (pan_rdata[9] && !pan_rdata[8])
                check(0, "R3 result-busy high after busy", pan_rdata[9:8], 0);
            if (prev_busy && !pan_rdata[8]) begin
                if (sbq.size() == 0) begin
                    check(0, "R3 completion without accepted command", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(pan_rdata[31:16] == {e.r2, e.r1}, "R2 result bytes",
                          pan_rdata[31:16], {e.r2, e.r1});
                end
            end
            prev_busy <= pan_rdata[8];
        end
    end

    task automatic m_init();
        for (int l = 0; l < 8; l++) len[l] = 0;
        for (int i = 0; i < 32; i++) ord[0][i] = i;
        len[0] = 32;
    endtask

    task automatic m_find(input int o, output int l, output int p);
        l = -1; p = -1;
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < len[k]; j++)
                if (ord[k][j] == o) begin l = k; p = j; end
    endtask

    task automatic m_remove(input int o);
        int l, p;
        m_find(o, l, p);
        for (int j = p; j < len[l] - 1; j++) ord[l][j] = ord[l][j+1];
        len[l]--;
    endtask

    task automatic m_insert(input int l, input int p, input int o);
        for (int j = len[l]; j > p; j--) ord[l][j] = ord[l][j-1];
        ord[l][p] = o;
        len[l]++;
    endtask

    task automatic check_lists(input string tag);
        for (int l = 0; l < 8; l++) begin
            bit ok = 1;
            int act = 0, exp = 0;
            lst_sel = 3'(l);
            #1;
            if (len[l] == 0) begin
                if (!lst_empty) begin ok = 0; act = 1; exp = 0; end
            end else begin
                if (lst_empty || lst_head != 8'(ord[l][0])) begin
                    ok = 0; act = lst_head; exp = ord[l][0];
                end
                for (int k = 0; k < len[l]; k++) begin
                    int nx;
                    nx = (k == len[l] - 1) ? ord[l][k] : ord[l][k+1];
                    obj_sel = 5'(ord[l][k]);
                    #1;
                    if (ok && (obj_next != 8'(nx) || obj_list != 4'(l))) begin
                        ok = 0; act = {obj_list, obj_next}; exp = (l << 8) | nx;
                    end
                end
            end
            check(ok, $sformatf("%s R11 list %0d", tag, l), act, exp);
        end
    endtask

    // driver: computes the expected outcome, pushes it, issues the command
    task automatic cmd(input int code, input int a1, input int a2, input string tag,
                       input bit poke = 0);
        bit err = 0;
        int obj = a1, l, p;
        exp_t e;
        case (code)
            0, 1: ;
            2: err = (a1 >= 32) || (a2 >= 8);
            3: begin err = (len[0] == 0) || (a2 >= 8); if (len[0] > 0) obj = ord[0][0]; end
            4, 6: err = (a1 >= 32) || (a2 >= 32) || (a1 == a2);
            5, 7: begin
                err = (len[0] == 0) || (a2 >= 32);
                if (len[0] > 0) begin obj = ord[0][0]; if (obj == a2) err = 1; end
            end
            default: err = 1;
        endcase
        e.r1 = (err || code <= 1) ? 8'(a1) : 8'(obj);
        e.r2 = {err, 7'(a2)};
        if (!err) begin
            case (code)
                1: m_init();
                2, 3: begin m_remove(obj); m_insert(a2, len[a2], obj); end
                4, 5: begin m_remove(obj); m_find(a2, l, p); m_insert(l, p, obj); end
                6, 7: begin m_remove(obj); m_find(a2, l, p); m_insert(l, p + 1, obj); end
                default: ;
            endcase
        end
        sbq.push_back(e);
        @(negedge clk);
        pan_wdata = {8'(a2), 8'(a1), 8'h00, 8'(code)};
        pan_we = 1'b1;
        @(negedge clk);
        pan_we = 1'b0;
        check(pan_rdata[9:8] == 2'b11, "R3 busy and result-busy after write",
              pan_rdata[9:8], 3);
        if (poke) begin
            pan_wdata = {8'd2, 8'd20, 8'h00, 8'h02};
            pan_we = 1'b1;
            @(negedge clk);
            pan_we = 1'b0;
        end
        while (pan_rdata[8]) @(negedge clk);
        check(pan_rdata[7:0] == 8'(code), {tag, " R2 command byte"}, pan_rdata[7:0], code);
        check(pan_rdata[31] == err, {tag, " error flag"}, pan_rdata[31], err);
        check_lists(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_init();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pan_rdata[15:8] == 8'h00, "R2 idle status after reset", pan_rdata[15:8], 0);
        check_lists("R1 reset");

        cmd(2, 5, 3, "R4 into empty list");
        cmd(2, 7, 3, "R4 onto non-empty list");
        cmd(2, 5, 3, "R4 to tail of own list");
        cmd(3, 0, 1, "R5 dynamic allocate");
        cmd(4, 9, 5, "R6 before middle");
        cmd(4, 10, 7, "R6 before head");
        cmd(5, 0, 10, "R6 dynamic before");
        cmd(6, 12, 5, "R7 behind tail");
        cmd(6, 13, 10, "R7 behind middle");
        cmd(7, 0, 0, "R7 dynamic behind");
        cmd(6, 3, 9, "R7 move across lists");

        cmd(2, 40, 3, "R9 object out of range");
        cmd(2, 4, 9, "R9 list out of range");
        cmd(4, 4, 33, "R9 target out of range");
        cmd(4, 9, 9, "R9 object equals target");
        cmd(9, 1, 2, "R9 undefined code");

        cmd(0, 8'h55, 8'h22, "R10 no-op");
        cmd(0, 8'h11, 8'h01, "R3 write during busy", 1);
        cmd(4, 14, 12, "R3 write during long walk", 1);

        while (len[0] > 0) cmd(3, 0, 4, "R5 drain pool");
        cmd(3, 6, 2, "R8 dynamic allocate on empty pool");
        cmd(5, 6, 12, "R8 dynamic before on empty pool");
        cmd(7, 6, 12, "R8 dynamic behind on empty pool");

        cmd(1, 0, 0, "R1 initialise command");
        cmd(3, 0, 2, "R5 allocate after initialise");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R3 all commands completed", sbq.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule